// File: doc/BRIEF.md
# PCI Configuration Address/Data Port

This block gives a host an indirect path into the configuration space of the functions behind a PCI or PCI Express root complex. The host first writes a 32-bit selector word into a pointer register. It then reads or writes a data window. Each data access becomes exactly one configuration transaction on a simple downstream request/response interface. That transaction carries the bus, device, function, dword register index, byte enables and lane-aligned write data.

The pointer register sits at host offset 0x0 and the data window at offset 0x4. The width of a data access and the lanes it touches come from the host size code and the low offset bits. Downstream data is always little-endian. The host path stalls until the transaction completes, and only one transaction is ever outstanding.

The parameter `EXPRESS` chooses between two variants. In conventional mode, the low-numbered devices on the local bus are fenced off. In express mode, four extra register-index bits are taken from the selector word, which gives each function 4 KB of configuration space.

Top module: `cfg_port`

## Requirements
- R1: A host access at offsets 0x0..0x3 targets the pointer register as a full word, whatever the size code. A write stores the word. A read returns the last stored word, and reads 0 after reset.
- R2: For an issued access, cfg_bus comes from selector bits 23:16, cfg_dev from bits 15:11, cfg_fn from bits 10:8, and cfg_dword[5:0] from bits 7:2.
- R3: With EXPRESS=1, cfg_dword[9:6] equals selector bits 27:24. With EXPRESS=0, cfg_dword[9:6] is 0 whatever those bits hold.
- R4: When selector bit 31 is clear, a data access raises no cfg_req. A read returns all ones masked to the access width, and a write is discarded.
- R5: With EXPRESS=0, a data access whose bus equals LOCAL_BUS (default 0) and whose device is below LOW_DEV_LIMIT (default 10) is treated like R4. Device LOW_DEV_LIMIT itself is not fenced, and nothing is fenced on other buses or with EXPRESS=1.
- R6: Size code 0 (byte) at offset 0x4+k sets cfg_be to 1<<k. The write byte appears on lane k, which is cfg_wdata bits 8k+7:8k. A read returns lane k in host_rdata[7:0] with the upper bits zero.
- R7: Size code 1 (halfword) at offset 0x4 gives cfg_be 4'b0011, and at offset 0x6 gives 4'b1100. The value is right-justified in host_rdata[15:0].
- R8: Size code 2 or 3 (word) gives cfg_be 4'b1111. Host bits 7:0 map to lane 0, and so on upwards, in both directions.
- R9: A completion with cfg_rsp_ok low gives read data of all ones masked to the access width.
- R10: cfg_req is a one-cycle pulse issued only while idle. host_done pulses once per access: one cycle after the request for pointer accesses and fenced accesses, and one cycle after cfg_rsp_valid for issued accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until host_done |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_off | input | 3 | Byte offset within the port (0x0..0x7) |
| host_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| host_wdata | input | 32 | Right-justified host write data |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Right-justified read data, valid with host_done |
| cfg_req | output | 1 | One-cycle downstream transaction pulse |
| cfg_we | output | 1 | Transaction is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_dword | output | 10 | Dword register index |
| cfg_be | output | 4 | Byte-lane enables |
| cfg_wdata | output | 32 | Lane-aligned little-endian write data |
| cfg_rsp_valid | input | 1 | Completion strobe |
| cfg_rsp_ok | input | 1 | A function claimed the transaction |
| cfg_rsp_data | input | 32 | Completion data, all four lanes |

## Verification
The bench builds two copies side by side. One uses EXPRESS=0 and the other EXPRESS=1, and both keep LOCAL_BUS=0 and LOW_DEV_LIMIT=10. The conventional copy reaches the fence boundary (devices 4, 9 and 10 on bus 0, and device 3 on bus 2). It also shows that stray high selector bits are dropped from the register index. The express copy reaches the extended index bits and shows that the same low devices are reachable there. Each copy has its own behavioural model of four functions with a fixed completion latency, so the stall timing is exact.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned DW_W   = 10;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} seq_state_e;

  typedef struct packed {
    logic       en;
    logic [3:0] ext;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
  } cfg_addr_t;

  function automatic logic [LANES-1:0] f_lane_be(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: return 4'b0001 << off;
      SZ_HALF: return off[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [1:0] f_lane_base(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      SZ_BYTE: return off;
      SZ_HALF: return {off[1], 1'b0};
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] f_width_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] f_spread(input logic [1:0] sz, input logic [WORD_W-1:0] wd);
    case (sz)
      SZ_BYTE: return {4{wd[7:0]}};
      SZ_HALF: return {2{wd[15:0]}};
      default: return wd;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] f_extract(input logic [1:0] sz, input logic [1:0] off,
                                                  input logic [WORD_W-1:0] d);
    logic [4:0] sh;
    sh = {f_lane_base(sz, off), 3'b000};
    return (d >> sh) & f_width_mask(sz);
  endfunction

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
  import cfg_port_pkg::*;
#(
  parameter bit EXPRESS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] word_o,
  output cfg_addr_t         fld_o
);

  logic [WORD_W-1:0] word_q;
  logic [3:0]        ext_w;

  always_ff @(posedge clk) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= wr_word;
  end

  generate
    if (EXPRESS) begin : g_ext
      assign ext_w = word_q[27:24];
    end else begin : g_noext
      assign ext_w = 4'h0;
    end
  endgenerate

  always_comb begin
    fld_o.en  = word_q[31];
    fld_o.ext = ext_w;
    fld_o.bus = word_q[23:16];
    fld_o.dev = word_q[15:11];
    fld_o.fn  = word_q[10:8];
    fld_o.dw  = word_q[7:2];
  end

  assign word_o = word_q;

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(word_o));

endmodule

// File: rtl/cfg_gate.sv
module cfg_gate #(
  parameter bit EXPRESS       = 1'b0,
  parameter int LOCAL_BUS     = 0,
  parameter int LOW_DEV_LIMIT = 10
) (
  input  logic       en,
  input  logic [7:0] bus,
  input  logic [4:0] dev,
  output logic       fenced,
  output logic       issue_ok
);

  logic local_hit;

  assign local_hit = (int'(bus) == LOCAL_BUS) && (int'(dev) < LOW_DEV_LIMIT);
  assign fenced    = (EXPRESS == 1'b0) && local_hit;
  assign issue_ok  = en && !fenced;

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [2:0]        host_off,
  input  logic [1:0]        host_size,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic [WORD_W-1:0] addr_word,
  input  cfg_addr_t         fld,
  input  logic              issue_ok,
  output logic              addr_wr,
  output logic              host_done,
  output logic [WORD_W-1:0] host_rdata,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [7:0]        cfg_bus,
  output logic [4:0]        cfg_dev,
  output logic [2:0]        cfg_fn,
  output logic [DW_W-1:0]   cfg_dword,
  output logic [LANES-1:0]  cfg_be,
  output logic [WORD_W-1:0] cfg_wdata,
  input  logic              cfg_rsp_valid,
  input  logic              cfg_rsp_ok,
  input  logic [WORD_W-1:0] cfg_rsp_data
);

  seq_state_e st_q;
  logic [1:0] size_q;
  logic [1:0] lane_off_q;

  // named events for the assertions
  logic is_data, accept, accept_local, accept_issue, rsp_take;

  assign is_data      = host_off[2];
  assign accept       = (st_q == ST_IDLE) && host_req;
  assign accept_local = accept && (!is_data || !issue_ok);
  assign accept_issue = accept && is_data && issue_ok;
  assign rsp_take     = (st_q == ST_WAIT) && cfg_rsp_valid;
  assign addr_wr      = accept && !is_data && host_wr;
  assign host_done    = (st_q == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cfg_req    <= 1'b0;
      cfg_we     <= 1'b0;
      cfg_bus    <= '0;
      cfg_dev    <= '0;
      cfg_fn     <= '0;
      cfg_dword  <= '0;
      cfg_be     <= '0;
      cfg_wdata  <= '0;
      size_q     <= '0;
      lane_off_q <= '0;
      host_rdata <= '0;
    end else begin
      cfg_req <= accept_issue;
      case (st_q)
        ST_IDLE: begin
          if (accept_local) begin
            if (!is_data)     host_rdata <= addr_word;
            else if (host_wr) host_rdata <= '0;
            else              host_rdata <= f_width_mask(host_size);
            st_q <= ST_RESP;
          end else if (accept_issue) begin
            cfg_we     <= host_wr;
            cfg_bus    <= fld.bus;
            cfg_dev    <= fld.dev;
            cfg_fn     <= fld.fn;
            cfg_dword  <= {fld.ext, fld.dw};
            cfg_be     <= f_lane_be(host_size, host_off[1:0]);
            cfg_wdata  <= f_spread(host_size, host_wdata);
            size_q     <= host_size;
            lane_off_q <= host_off[1:0];
            st_q       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_take) begin
            if (cfg_we)          host_rdata <= '0;
            else if (cfg_rsp_ok) host_rdata <= f_extract(size_q, lane_off_q, cfg_rsp_data);
            else                 host_rdata <= f_width_mask(size_q);
            st_q <= ST_RESP;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> !cfg_req);

  // R10
  done_waits_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !cfg_rsp_valid) |=> !host_done);

  // R4
  issue_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> $past(issue_ok) && $past(fld.en));

  // R6
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> ($countones(cfg_be) == 1 || cfg_be == 4'b0011 ||
                 cfg_be == 4'b1100 || cfg_be == 4'b1111));

  // R9
  unclaimed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !cfg_rsp_ok && !cfg_we) |=> (host_rdata == f_width_mask(size_q)));

endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_port_pkg::*;
#(
  parameter bit EXPRESS       = 1'b0,
  parameter int LOCAL_BUS     = 0,
  parameter int LOW_DEV_LIMIT = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_wr,
  input  logic [2:0]  host_off,
  input  logic [1:0]  host_size,
  input  logic [31:0] host_wdata,
  output logic        host_done,
  output logic [31:0] host_rdata,
  output logic        cfg_req,
  output logic        cfg_we,
  output logic [7:0]  cfg_bus,
  output logic [4:0]  cfg_dev,
  output logic [2:0]  cfg_fn,
  output logic [9:0]  cfg_dword,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_rsp_valid,
  input  logic        cfg_rsp_ok,
  input  logic [31:0] cfg_rsp_data
);

  logic [WORD_W-1:0] addr_word;
  cfg_addr_t         fld;
  logic              addr_wr;
  logic              fenced;
  logic              issue_ok;

  cfg_addr_latch #(.EXPRESS(EXPRESS)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (addr_wr),
    .wr_word (host_wdata),
    .word_o  (addr_word),
    .fld_o   (fld)
  );

  cfg_gate #(
    .EXPRESS       (EXPRESS),
    .LOCAL_BUS     (LOCAL_BUS),
    .LOW_DEV_LIMIT (LOW_DEV_LIMIT)
  ) u_gate (
    .en       (fld.en),
    .bus      (fld.bus),
    .dev      (fld.dev),
    .fenced   (fenced),
    .issue_ok (issue_ok)
  );

  cfg_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_req      (host_req),
    .host_wr       (host_wr),
    .host_off      (host_off),
    .host_size     (host_size),
    .host_wdata    (host_wdata),
    .addr_word     (addr_word),
    .fld           (fld),
    .issue_ok      (issue_ok),
    .addr_wr       (addr_wr),
    .host_done     (host_done),
    .host_rdata    (host_rdata),
    .cfg_req       (cfg_req),
    .cfg_we        (cfg_we),
    .cfg_bus       (cfg_bus),
    .cfg_dev       (cfg_dev),
    .cfg_fn        (cfg_fn),
    .cfg_dword     (cfg_dword),
    .cfg_be        (cfg_be),
    .cfg_wdata     (cfg_wdata),
    .cfg_rsp_valid (cfg_rsp_valid),
    .cfg_rsp_ok    (cfg_rsp_ok),
    .cfg_rsp_data  (cfg_rsp_data)
  );

  generate
    if (!EXPRESS) begin : g_conv_chk
      // R5
      local_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !((int'(cfg_bus) == LOCAL_BUS) && (int'(cfg_dev) < LOW_DEV_LIMIT)));

      // R3
      conv_ext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_dword[9:6] == 4'h0));
    end
  endgenerate

  // R10
  no_req_while_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> !cfg_req);

endmodule

// File: tb/cfg_func_model.sv
module cfg_func_model #(
  parameter int LAT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [7:0]  bus,
  input  logic [4:0]  dev,
  input  logic [2:0]  fn,
  input  logic [9:0]  dword,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic        rsp_valid,
  output logic        rsp_ok,
  output logic [31:0] rsp_data
);

  logic [31:0] mem [4][64];
  int          idx_q;
  logic [5:0]  dw_q;
  int          cnt;

  function automatic int claim(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f);
    if (b == 8'd0 && d == 5'd12 && f == 3'd0) return 0;
    if (b == 8'd0 && d == 5'd12 && f == 3'd1) return 1;
    if (b == 8'd2 && d == 5'd3  && f == 3'd0) return 2;
    if (b == 8'd0 && d == 5'd4  && f == 3'd0) return 3;
    return -1;
  endfunction

  initial begin
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 64; j++)
        mem[i][j] = 32'h1000_0000 * (i + 1) + 32'h00A0_0000 + j * 32'h0001_0101;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_data  <= '0;
      cnt       <= 0;
      idx_q     <= -1;
      dw_q      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (req) begin
        idx_q <= claim(bus, dev, fn);
        dw_q  <= dword[5:0];
        cnt   <= LAT;
        if (we && claim(bus, dev, fn) >= 0)
          for (int k = 0; k < 4; k++)
            if (be[k]) mem[claim(bus, dev, fn)][dword[5:0]][8*k +: 8] <= wdata[8*k +: 8];
      end else if (cnt > 1) begin
        cnt <= cnt - 1;
      end else if (cnt == 1) begin
        cnt       <= 0;
        rsp_valid <= 1'b1;
        rsp_ok    <= (idx_q >= 0);
        rsp_data  <= (idx_q >= 0) ? mem[idx_q][dw_q] : 32'hDEAD_BEEF;
      end
    end
  end

endmodule

// File: tb/test_cfg_port.sv
`timescale 1ns/1ps
module test_cfg_port;

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n = 1'b0;

  logic        h_req [2];
  logic        h_wr  [2];
  logic [2:0]  h_off [2];
  logic [1:0]  h_size[2];
  logic [31:0] h_wd  [2];
  logic        d_done[2];
  logic [31:0] d_rd  [2];
  logic        d_req [2];
  logic        d_we  [2];
  logic [7:0]  d_bus [2];
  logic [4:0]  d_dev [2];
  logic [2:0]  d_fn  [2];
  logic [9:0]  d_dw  [2];
  logic [3:0]  d_be  [2];
  logic [31:0] d_wd  [2];
  logic        r_val [2];
  logic        r_ok  [2];
  logic [31:0] r_data[2];

  cfg_port #(.EXPRESS(1'b0)) i_cfg_port (
    .clk(clk), .rst_n(rst_n), .host_req(h_req[0]), .host_wr(h_wr[0]), .host_off(h_off[0]),
    .host_size(h_size[0]), .host_wdata(h_wd[0]), .host_done(d_done[0]), .host_rdata(d_rd[0]),
    .cfg_req(d_req[0]), .cfg_we(d_we[0]), .cfg_bus(d_bus[0]), .cfg_dev(d_dev[0]), .cfg_fn(d_fn[0]),
    .cfg_dword(d_dw[0]), .cfg_be(d_be[0]), .cfg_wdata(d_wd[0]),
    .cfg_rsp_valid(r_val[0]), .cfg_rsp_ok(r_ok[0]), .cfg_rsp_data(r_data[0]));

  cfg_port #(.EXPRESS(1'b1)) i_cfg_port_x (
    .clk(clk), .rst_n(rst_n), .host_req(h_req[1]), .host_wr(h_wr[1]), .host_off(h_off[1]),
    .host_size(h_size[1]), .host_wdata(h_wd[1]), .host_done(d_done[1]), .host_rdata(d_rd[1]),
    .cfg_req(d_req[1]), .cfg_we(d_we[1]), .cfg_bus(d_bus[1]), .cfg_dev(d_dev[1]), .cfg_fn(d_fn[1]),
    .cfg_dword(d_dw[1]), .cfg_be(d_be[1]), .cfg_wdata(d_wd[1]),
    .cfg_rsp_valid(r_val[1]), .cfg_rsp_ok(r_ok[1]), .cfg_rsp_data(r_data[1]));

  for (genvar g = 0; g < 2; g++) begin : g_model
    cfg_func_model #(.LAT(3)) i_model (
      .clk(clk), .rst_n(rst_n), .req(d_req[g]), .we(d_we[g]), .bus(d_bus[g]), .dev(d_dev[g]),
      .fn(d_fn[g]), .dword(d_dw[g]), .be(d_be[g]), .wdata(d_wd[g]),
      .rsp_valid(r_val[g]), .rsp_ok(r_ok[g]), .rsp_data(r_data[g]));
  end

  typedef struct packed {
    logic        we;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [9:0]  dw;
    logic [3:0]  be;
    logic [31:0] wd;
  } req_t;

  req_t        q_req[$];
  logic [31:0] q_rd[$];
  int          n_vec = 0;
  int          n_bad = 0;
  int          cur = 0;
  string       cur_tag = "R1";
  logic [31:0] addr_sh[2];
  logic [31:0] shadow[2][4][64];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int claim(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f);
    case ({b, d, f})
      {8'd0, 5'd12, 3'd0}: return 0;
      {8'd0, 5'd12, 3'd1}: return 1;
      {8'd2, 5'd3,  3'd0}: return 2;
      {8'd0, 5'd4,  3'd0}: return 3;
      default:             return -1;
    endcase
  endfunction

  function automatic logic [31:0] sel(input bit en, input logic [3:0] ext, input logic [7:0] b,
                                      input logic [4:0] d, input logic [2:0] f, input logic [5:0] w);
    return {en, 3'b000, ext, b, d, f, w, 2'b00};
  endfunction

  // monitor: pops expectations as the designs produce results
  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < 2; m++) begin
        if (d_req[m]) begin
          if (m != cur || q_req.size() == 0) begin
            chk({"R10 unexpected request ", cur_tag}, 64'd1, 64'd0);
          end else begin
            chk(cur_tag, {d_we[m], d_bus[m], d_dev[m], d_fn[m], d_dw[m], d_be[m], d_wd[m]},
                q_req.pop_front());
          end
        end
      end
      if (d_done[cur] && !h_wr[cur]) begin
        if (q_rd.size() == 0) chk({"R10 unexpected read ", cur_tag}, 64'd1, 64'd0);
        else                  chk(cur_tag, d_rd[cur], q_rd.pop_front());
      end
    end
  end

  // driver: computes expectations from the requirements, then runs the access
  task automatic access(input int m, input bit wr, input logic [2:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, input string tag);
    logic [31:0] a, ones, rd, sp;
    logic [3:0]  be;
    logic [9:0]  dw;
    int nb, base, idx, lat, exp_lat;
    bit fence;
    cur = m;
    cur_tag = tag;
    exp_lat = 1;
    if (!off[2]) begin
      if (wr) addr_sh[m] = wd;
      else    q_rd.push_back(addr_sh[m]);
    end else begin
      a    = addr_sh[m];
      nb   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      base = (sz == 2'd0) ? int'(off[1:0]) : (sz == 2'd1) ? 2 * int'(off[1]) : 0;
      ones = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 32'd1);
      for (int k = 0; k < 4; k++) begin
        be[k] = (k >= base) && (k < base + nb);
        sp[8*k +: 8] = wd[8*(k % nb) +: 8];
      end
      dw    = {(m == 1) ? a[27:24] : 4'h0, a[7:2]};
      fence = (m == 0) && (a[23:16] == 8'd0) && (a[15:11] < 5'd10);
      if (a[31] && !fence) begin
        exp_lat = 6;
        q_req.push_back({wr, a[23:16], a[15:11], a[10:8], dw, be, sp});
        idx = claim(a[23:16], a[15:11], a[10:8]);
        if (wr && idx >= 0) begin
          for (int k = 0; k < 4; k++)
            if (be[k]) shadow[m][idx][dw[5:0]][8*k +: 8] = sp[8*k +: 8];
        end
        if (!wr) begin
          rd = '0;
          if (idx < 0) rd = ones;
          else for (int j = 0; j < nb; j++) rd[8*j +: 8] = shadow[m][idx][dw[5:0]][8*(base+j) +: 8];
          q_rd.push_back(rd);
        end
      end else if (!wr) begin
        q_rd.push_back(ones);
      end
    end
    h_wr[m] = wr; h_off[m] = off; h_size[m] = sz; h_wd[m] = wd; h_req[m] = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!d_done[m] && lat < 64);
    h_req[m] = 1'b0;
    // R10: exact stall length, one cycle for local completions
    chk({"R10 latency ", tag}, lat, exp_lat);
    @(negedge clk);
    if (q_req.size() != 0 || q_rd.size() != 0) begin
      chk({"R10 missing result ", tag}, q_req.size() + q_rd.size(), 0);
      q_req.delete();
      q_rd.delete();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      h_req[m] = 1'b0; h_wr[m] = 1'b0; h_off[m] = '0; h_size[m] = '0; h_wd[m] = '0;
      addr_sh[m] = '0;
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 64; j++)
          shadow[m][i][j] = 32'h1000_0000 * (i + 1) + 32'h00A0_0000 + j * 32'h0001_0101;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state: no pulses out of reset
    chk("R10 reset done", {d_done[0], d_done[1], d_req[0], d_req[1]}, 0);
    // R1 pointer reads zero after reset, in both modes
    access(0, 0, 3'd0, 2'd2, 0, "R1 reset pointer");
    access(1, 0, 3'd0, 2'd2, 0, "R1 reset pointer x");
    // R1 + R3: stray high bits stored, but dropped from the index in conventional mode
    access(0, 1, 3'd0, 2'd0, sel(1, 4'h5, 8'd0, 5'd12, 3'd0, 6'd3), "R1 pointer write");
    access(0, 0, 3'd2, 2'd0, 0, "R1 pointer readback");
    access(0, 0, 3'd4, 2'd2, 0, "R2 R3 word read");
    // R8 word write then read
    access(0, 1, 3'd4, 2'd3, 32'h1122_3344, "R8 word write");
    access(0, 0, 3'd4, 2'd2, 0, "R8 word read");
    // R6 byte lanes
    for (int k = 0; k < 4; k++) access(0, 1, 3'(4 + k), 2'd0, 32'hC0 + k, "R6 byte write");
    for (int k = 0; k < 4; k++) access(0, 0, 3'(4 + k), 2'd0, 0, "R6 byte read");
    // R7 halfwords
    access(0, 1, 3'd6, 2'd1, 32'h0000_BEEF, "R7 high half write");
    access(0, 0, 3'd4, 2'd1, 0, "R7 low half read");
    access(0, 0, 3'd6, 2'd1, 0, "R7 high half read");
    // R4 disabled: write dropped, read ones
    access(0, 1, 3'd0, 2'd2, sel(0, 4'h0, 8'd0, 5'd12, 3'd0, 6'd3), "R4 pointer clear en");
    access(0, 1, 3'd4, 2'd2, 32'h0BAD_0BAD, "R4 dropped write");
    access(0, 0, 3'd5, 2'd0, 0, "R4 disabled read");
    access(0, 1, 3'd0, 2'd2, sel(1, 4'h0, 8'd0, 5'd12, 3'd0, 6'd3), "R4 pointer set en");
    access(0, 0, 3'd4, 2'd2, 0, "R4 data unchanged");
    // R2 second function
    access(0, 1, 3'd0, 2'd2, sel(1, 4'h0, 8'd0, 5'd12, 3'd1, 6'd17), "R2 pointer fn1");
    access(0, 0, 3'd4, 2'd2, 0, "R2 fn1 read");
    // R5 fence boundary in conventional mode
    access(0, 1, 3'd0, 2'd2, sel(1, 4'h0, 8'd0, 5'd4, 3'd0, 6'd2), "R5 pointer dev4");
    access(0, 1, 3'd4, 2'd2, 32'h5555_5555, "R5 fenced write");
    access(0, 0, 3'd4, 2'd1, 0, "R5 fenced read");
    access(0, 1, 3'd0, 2'd2, sel(1, 4'h0, 8'd0, 5'd9, 3'd0, 6'd2), "R5 pointer dev9");
    access(0, 0, 3'd4, 2'd2, 0, "R5 dev9 fenced read");
    access(0, 1, 3'd0, 2'd2, sel(1, 4'h0, 8'd0, 5'd10, 3'd0, 6'd2), "R5 pointer dev10");
    access(0, 0, 3'd4, 2'd2, 0, "R5 dev10 issued read");
    access(0, 1, 3'd0, 2'd2, sel(1, 4'h0, 8'd2, 5'd3, 3'd0, 6'd9), "R5 pointer bus2");
    access(0, 0, 3'd4, 2'd2, 0, "R5 bus2 dev3 read");
    // R9 unclaimed halfword and byte
    access(0, 1, 3'd0, 2'd2, sel(1, 4'h0, 8'd5, 5'd20, 3'd2, 6'd1), "R9 pointer none");
    access(0, 0, 3'd6, 2'd1, 0, "R9 unclaimed half");
    access(0, 0, 3'd7, 2'd0, 0, "R9 unclaimed byte");
    // R3 + R5 express mode: extended index, no fence on local low devices
    access(1, 1, 3'd0, 2'd2, sel(1, 4'hA, 8'd0, 5'd4, 3'd0, 6'd7), "R3 pointer ext");
    access(1, 0, 3'd4, 2'd2, 0, "R3 ext word read");
    access(1, 1, 3'd5, 2'd0, 32'h0000_0077, "R5 express byte write");
    access(1, 0, 3'd4, 2'd2, 0, "R5 express readback");
    // R4 in express mode too
    access(1, 1, 3'd0, 2'd2, sel(0, 4'hA, 8'd0, 5'd4, 3'd0, 6'd7), "R4 pointer x");
    access(1, 0, 3'd4, 2'd2, 0, "R4 express disabled read");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule